// File: doc/BRIEF.md
# Reservation Station with Broadcast Wakeup

This block holds a small pool of instructions that are waiting for operands. Each entry stores an operation code and two source slots. A slot is either ready, in which case it holds the operand value, or waiting, in which case it holds the tag of the instruction that will produce the value. Every cycle, all waiting slots compare their tags with every result broadcast bus at the same time. A slot whose tag matches a valid broadcast takes that value and becomes ready.

Entries whose two slots are both ready compete for a fixed number of issue ports. The oldest ready entries win. The oldest goes to port 0, the next oldest to port 1, and so on. An issued entry leaves the pool. A dispatch side fills a free entry each cycle and is refused while the pool is full. Renaming, execution and retirement belong to other blocks.

Top module: `rs_wakeup_pool`

## Requirements
- R1: After reset the pool is empty: `full` is 0 and every `iss_valid` bit is 0.
- R2: At dispatch, a source slot is ready when its `*_rdy` input is 1. The slot then holds `*_val`. When `*_rdy` is 0 the slot waits on `*_tag`. An issued entry presents its stored operation and both operand values on its port.
- R3: An entry issues only when both of its source slots are ready. A single waiting slot keeps it from issuing.
- R4: A valid broadcast whose tag matches a waiting slot in any entry loads the broadcast value into that slot in the same clock edge. All matching slots across all entries wake together. The entry can issue in the cycle after the broadcast.
- R5: A dispatch whose waiting slot matches a broadcast in the same cycle captures that value at dispatch, so the slot is ready from the next cycle.
- R6: At most PORTS entries issue in a cycle. Ready entries beyond that stay in the pool and compete again in the next cycle.
- R7: Among ready entries, the oldest by dispatch order goes to port 0, the next oldest to port 1, and so on. Used ports are always the lowest-numbered ones.
- R8: An issued entry is freed at the end of its issue cycle. `full` is 1 exactly when every entry is occupied. A dispatch presented while `full` is 1 is dropped.
- R9: Every one of the BUSES broadcast buses is compared in every cycle. A match on any bus wakes the slot. Bus b uses bits [b*TAG_W +: TAG_W] of `bc_tag` and bits [b*DATA_W +: DATA_W] of `bc_val`.
- R10: A newly dispatched entry does not issue in its dispatch cycle. With both slots ready, it issues no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | OP_W | Operation code of the dispatched instruction |
| disp_a_rdy | input | 1 | Source A already holds its value |
| disp_a_tag | input | TAG_W | Producer tag for source A |
| disp_a_val | input | DATA_W | Value for source A |
| disp_b_rdy | input | 1 | Source B already holds its value |
| disp_b_tag | input | TAG_W | Producer tag for source B |
| disp_b_val | input | DATA_W | Value for source B |
| full | output | 1 | No free entry; dispatch is dropped |
| bc_valid | input | BUSES | Broadcast valid, one bit per bus |
| bc_tag | input | BUSES*TAG_W | Broadcast producer tags |
| bc_val | input | BUSES*DATA_W | Broadcast result values |
| iss_valid | output | PORTS | Issue valid, one bit per port |
| iss_op | output | PORTS*OP_W | Issued operation codes |
| iss_a | output | PORTS*DATA_W | Issued source A values |
| iss_b | output | PORTS*DATA_W | Issued source B values |

## Verification
The hardest state to reach from the ports is a full pool in which more entries become ready in one cycle than there are ports. In that state, age order and the retry of the losers are both visible at once. A directed sequence builds it. It fills every entry with instructions that wait on one shared tag and offers an extra dispatch while the pool is full. It then wakes all of them with a single broadcast on the second bus. A same-cycle dispatch-and-broadcast case covers capture at dispatch. Long random runs over a small tag space then mix partial wakeups, several buses and back-pressure. A bench reference model with dispatch sequence numbers predicts every port in every cycle.

// File: rtl/rs_wakeup_pool.sv
module rs_wakeup_pool #(
  parameter int ENTRIES = 4,
  parameter int PORTS   = 2,
  parameter int BUSES   = 2,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  input  logic [OP_W-1:0]         disp_op,
  input  logic                    disp_a_rdy,
  input  logic [TAG_W-1:0]        disp_a_tag,
  input  logic [DATA_W-1:0]       disp_a_val,
  input  logic                    disp_b_rdy,
  input  logic [TAG_W-1:0]        disp_b_tag,
  input  logic [DATA_W-1:0]       disp_b_val,
  output logic                    full,
  input  logic [BUSES-1:0]        bc_valid,
  input  logic [BUSES*TAG_W-1:0]  bc_tag,
  input  logic [BUSES*DATA_W-1:0] bc_val,
  output logic [PORTS-1:0]        iss_valid,
  output logic [PORTS*OP_W-1:0]   iss_op,
  output logic [PORTS*DATA_W-1:0] iss_a,
  output logic [PORTS*DATA_W-1:0] iss_b
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, ra, rb, rdy, issued;
  logic [OP_W-1:0]    op_q [ENTRIES];
  logic [TAG_W-1:0]   ta_q [ENTRIES];
  logic [TAG_W-1:0]   tb_q [ENTRIES];
  logic [DATA_W-1:0]  va_q [ENTRIES];
  logic [DATA_W-1:0]  vb_q [ENTRIES];
  logic [ENTRIES-1:0] older [ENTRIES];
  logic [ENTRIES-1:0] sel [PORTS];
  logic [IDX_W-1:0]   free_idx;
  logic               accept;

  function automatic logic [DATA_W:0] snoop(input logic [TAG_W-1:0] t,
      input logic [BUSES-1:0] bv, input logic [BUSES*TAG_W-1:0] bt,
      input logic [BUSES*DATA_W-1:0] bd);
    logic [DATA_W:0] r;
    r = '0;
    for (int b = 0; b < BUSES; b++)
      if (bv[b] && bt[b*TAG_W +: TAG_W] == t) r = {1'b1, bd[b*DATA_W +: DATA_W]};
    return r;
  endfunction

  assign rdy    = vld & ra & rb;
  assign full   = &vld;
  assign accept = disp_valid & ~full;

  always_comb begin
    logic [ENTRIES-1:0] left;
    logic cand;
    left   = rdy;
    issued = '0;
    for (int p = 0; p < PORTS; p++) begin
      sel[p] = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        cand = left[i];
        for (int j = 0; j < ENTRIES; j++)
          if (j != i && left[j] && older[j][i]) cand = 1'b0;
        sel[p][i] = cand;
      end
      left   = left & ~sel[p];
      issued = issued | sel[p];
    end
  end

  always_comb begin
    iss_op = '0; iss_a = '0; iss_b = '0;
    for (int p = 0; p < PORTS; p++) begin
      iss_valid[p] = |sel[p];
      for (int i = 0; i < ENTRIES; i++)
        if (sel[p][i]) begin
          iss_op[p*OP_W +: OP_W]     = op_q[i];
          iss_a[p*DATA_W +: DATA_W]  = va_q[i];
          iss_b[p*DATA_W +: DATA_W]  = vb_q[i];
        end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; ra <= '0; rb <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        op_q[i] <= '0; ta_q[i] <= '0; tb_q[i] <= '0;
        va_q[i] <= '0; vb_q[i] <= '0; older[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        logic [DATA_W:0] ha, hb;
        ha = snoop(ta_q[i], bc_valid, bc_tag, bc_val);
        hb = snoop(tb_q[i], bc_valid, bc_tag, bc_val);
        if (issued[i]) vld[i] <= 1'b0;
        else if (vld[i]) begin
          if (!ra[i] && ha[DATA_W]) begin ra[i] <= 1'b1; va_q[i] <= ha[DATA_W-1:0]; end
          if (!rb[i] && hb[DATA_W]) begin rb[i] <= 1'b1; vb_q[i] <= hb[DATA_W-1:0]; end
        end
      end
      if (accept) begin
        logic [DATA_W:0] da, db;
        da = snoop(disp_a_tag, bc_valid, bc_tag, bc_val);
        db = snoop(disp_b_tag, bc_valid, bc_tag, bc_val);
        vld[free_idx]  <= 1'b1;
        op_q[free_idx] <= disp_op;
        ta_q[free_idx] <= disp_a_tag;
        tb_q[free_idx] <= disp_b_tag;
        ra[free_idx]   <= disp_a_rdy | da[DATA_W];
        rb[free_idx]   <= disp_b_rdy | db[DATA_W];
        va_q[free_idx] <= disp_a_rdy ? disp_a_val : da[DATA_W-1:0];
        vb_q[free_idx] <= disp_b_rdy ? disp_b_val : db[DATA_W-1:0];
        for (int j = 0; j < ENTRIES; j++)
          if (j != int'(free_idx)) begin
            older[free_idx][j] <= 1'b0;
            older[j][free_idx] <= 1'b1;
          end
      end
    end
  end
endmodule

// File: rtl/rs_wakeup_pool_chk.sv
module rs_wakeup_pool_chk #(
  parameter int ENTRIES = 4,
  parameter int PORTS   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] vld,
  input logic               full,
  input logic               disp_valid,
  input logic [PORTS-1:0]   iss_valid
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_empty_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld == '0) |-> (iss_valid == '0));

  p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && iss_valid == '0) |=> full);

  p_entry_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ($countones(vld) == $past($countones(vld)) - $past($countones(iss_valid))
                                  + int'($past(disp_valid && !full))));

  generate
    for (genvar p = 1; p < PORTS; p++) begin : g_port_order
      p_low_ports_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[p] |-> iss_valid[p-1]);
    end
  endgenerate
endmodule

bind rs_wakeup_pool rs_wakeup_pool_chk #(.ENTRIES(ENTRIES), .PORTS(PORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .vld(vld), .full(full),
  .disp_valid(disp_valid), .iss_valid(iss_valid));

// File: tb/rs_wakeup_pool_tb_top.sv
module rs_wakeup_pool_tb_top;
  localparam int EN = 4, PO = 2, BU = 2, TW = 4, DW = 16, OW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_a_rdy = 1'b0, disp_b_rdy = 1'b0;
  logic [OW-1:0] disp_op = '0;
  logic [TW-1:0] disp_a_tag = '0, disp_b_tag = '0;
  logic [DW-1:0] disp_a_val = '0, disp_b_val = '0;
  logic full;
  logic [BU-1:0] bc_valid = '0;
  logic [BU*TW-1:0] bc_tag = '0;
  logic [BU*DW-1:0] bc_val = '0;
  logic [PO-1:0] iss_valid;
  logic [PO*OW-1:0] iss_op;
  logic [PO*DW-1:0] iss_a, iss_b;

  always #4 clk = ~clk;

  rs_wakeup_pool #(.ENTRIES(EN), .PORTS(PO), .BUSES(BU), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a_rdy(disp_a_rdy), .disp_a_tag(disp_a_tag), .disp_a_val(disp_a_val),
    .disp_b_rdy(disp_b_rdy), .disp_b_tag(disp_b_tag), .disp_b_val(disp_b_val),
    .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b));

  int total = 0, bad = 0;
  bit m_vld [EN], m_ra [EN], m_rb [EN];
  int m_seq [EN], m_op [EN], m_ta [EN], m_tb [EN], m_va [EN], m_vb [EN];
  int seq_next = 0;

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit dv, int op, bit ar, int at, int av,
                      bit br, int bt, int bv, bit [1:0] bcv,
                      int t0, int v0, int t1, int v1);
    int pick [PO];
    bit taken [EN];
    bit mfull;
    @(negedge clk);
    disp_valid = dv; disp_op = OW'(op);
    disp_a_rdy = ar; disp_a_tag = TW'(at); disp_a_val = DW'(av);
    disp_b_rdy = br; disp_b_tag = TW'(bt); disp_b_val = DW'(bv);
    bc_valid = bcv; bc_tag = {TW'(t1), TW'(t0)}; bc_val = {DW'(v1), DW'(v0)};
    #1;
    mfull = 1'b1;
    for (int i = 0; i < EN; i++) begin
      taken[i] = 1'b0;
      if (!m_vld[i]) mfull = 1'b0;
    end
    check(req, "full", int'(full), int'(mfull));
    for (int p = 0; p < PO; p++) begin
      pick[p] = -1;
      for (int i = 0; i < EN; i++)
        if (m_vld[i] && m_ra[i] && m_rb[i] && !taken[i] &&
            (pick[p] < 0 || m_seq[i] < m_seq[pick[p]])) pick[p] = i;
      if (pick[p] >= 0) taken[pick[p]] = 1'b1;
      check(req, $sformatf("iss_valid[%0d]", p), int'(iss_valid[p]), int'(pick[p] >= 0));
      if (pick[p] >= 0 && iss_valid[p]) begin
        check(req, "iss_op", int'(iss_op[p*OW +: OW]), m_op[pick[p]]);
        check(req, "iss_a", int'(iss_a[p*DW +: DW]), m_va[pick[p]]);
        check(req, "iss_b", int'(iss_b[p*DW +: DW]), m_vb[pick[p]]);
      end
    end
    for (int i = 0; i < EN; i++) begin
      if (taken[i]) m_vld[i] = 1'b0;
      else if (m_vld[i]) begin
        if (!m_ra[i] && bcv[0] && m_ta[i] == t0) begin m_ra[i] = 1; m_va[i] = v0; end
        if (!m_ra[i] && bcv[1] && m_ta[i] == t1) begin m_ra[i] = 1; m_va[i] = v1; end
        if (!m_rb[i] && bcv[0] && m_tb[i] == t0) begin m_rb[i] = 1; m_vb[i] = v0; end
        if (!m_rb[i] && bcv[1] && m_tb[i] == t1) begin m_rb[i] = 1; m_vb[i] = v1; end
      end
    end
    if (dv && !mfull) begin
      int k;
      k = -1;
      for (int i = 0; i < EN; i++) if (!m_vld[i] && !taken[i] && k < 0) k = i;
      m_vld[k] = 1; m_seq[k] = seq_next++; m_op[k] = op;
      m_ta[k] = at; m_tb[k] = bt;
      m_ra[k] = ar; m_va[k] = av; m_rb[k] = br; m_vb[k] = bv;
      if (!ar && bcv[0] && at == t0) begin m_ra[k] = 1; m_va[k] = v0; end
      if (!ar && bcv[1] && at == t1) begin m_ra[k] = 1; m_va[k] = v1; end
      if (!br && bcv[0] && bt == t0) begin m_rb[k] = 1; m_vb[k] = v0; end
      if (!br && bcv[1] && bt == t1) begin m_rb[k] = 1; m_vb[k] = v1; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < EN; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "full after reset", int'(full), 0);
    check("R1", "iss_valid after reset", int'(iss_valid), 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 / R10: ready dispatch, not issued before the next cycle
    step("R2", 1, 3, 1, 0, 111, 1, 0, 222, 2'b00, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    // R8 / R3: fill with entries waiting on tag 5, extra dispatch while full is dropped
    step("R3", 1, 1, 0, 5, 0, 1, 0, 10, 2'b00, 0, 0, 0, 0);
    step("R3", 1, 2, 1, 0, 20, 0, 5, 0, 2'b00, 0, 0, 0, 0);
    step("R3", 1, 4, 0, 5, 0, 0, 5, 0, 2'b00, 0, 0, 0, 0);
    step("R3", 1, 6, 0, 5, 0, 1, 0, 40, 2'b00, 0, 0, 0, 0);
    step("R8", 1, 9, 1, 0, 77, 1, 0, 88, 2'b00, 0, 0, 0, 0);
    // R9: one broadcast on bus 1 wakes every entry
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 0, 0, 5, 555);
    // R6 / R7: four ready, two ports, oldest first, rest retry
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    // R5: dispatch captures a same-cycle broadcast on bus 0
    step("R5", 1, 7, 0, 3, 0, 1, 0, 30, 2'b01, 3, 333, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int t0, t1;
      t0 = $urandom_range(0, 15);
      t1 = $urandom_range(0, 15);
      if (t1 == t0) t1 = t0 ^ 1;
      step("R4", ($urandom_range(0, 9) < 7), $urandom_range(0, 15),
           $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 65535),
           $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 65535),
           2'($urandom_range(0, 3)), t0, $urandom_range(0, 65535),
           t1, $urandom_range(0, 65535));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule